// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block sits between a simple CPU-side memory request port and an external SRAM reached over a multiplexed bus. One 8-bit port carries the low address byte and then the data. An address-latch-enable strobe lets an external latch capture the low byte. A separate port drives the high address byte for the whole access. Active-low read and write strobes complete the bus.

An 8-bit control register switches the interface on. While it is on, the block claims the shared pins through an override output. The same register can divide the external address space into a lower and an upper sector at a programmable boundary. Each sector has its own two-bit wait-state setting. Each access runs an address phase, a strobe phase stretched by the wait states, and an optional address-hold phase. The CPU side sees a busy flag while a cycle is in flight. Read data comes back with a one-cycle valid pulse.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, the control register reads 0, `pin_override` is 0, `req_busy` is 0, `ale` is 0, and both `rd_n` and `wr_n` are 1.
- R2: Writing `cfg_wdata` with `cfg_we` high stores the byte, and `cfg_rdata` returns it from the next cycle. Field layout: bit 7 is the enable, bits 6:4 are the split code, bits 3:2 are the upper-sector wait setting, and bits 1:0 are the lower-sector wait setting.
- R3: `pin_override` equals the stored enable bit. While the enable bit is 0, a request is ignored: `req_busy` stays 0, and `ale`, `rd_n` and `wr_n` stay idle.
- R4: With split code 0, every address uses the upper-sector wait setting (bits 3:2).
- R5: With split code k in 1..7, an address below k*0x2000 uses the lower-sector setting (bits 1:0). An address at or above k*0x2000 uses the upper-sector setting.
- R6: The wait setting gives the number of strobe-low cycles: 00 gives 1, 01 gives 2, 10 gives 3, 11 gives 3. Setting 11 also adds one address-hold cycle with both strobes high. `req_busy` is therefore high for 2, 3, 4 or 5 cycles.
- R7: Each accepted access begins with exactly one cycle of `ale` high. In that cycle `ad_oe` is 1 and `ad_out` carries address bits 7:0. `ah_out` carries address bits 15:8 in every busy cycle.
- R8: During a write, `wr_n` is low, `ad_oe` is 1 and `ad_out` carries the write data.
- R9: During a read, `rd_n` is low and `ad_oe` is 0. `rd_data` takes `ad_in` from the last clock edge of the `rd_n`-low phase. `rd_valid` is high for the single cycle after that edge.
- R10: `rd_n` and `wr_n` are never low in the same cycle, and `ale` is never high while a strobe is low.
- R11: A request is accepted only when the controller is idle. A request that is raised and dropped while `req_busy` is high starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| req_valid | input | 1 | CPU access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | External byte address |
| req_wdata | input | 8 | Write data |
| req_busy | output | 1 | Access in progress |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle read-data pulse |
| pin_override | output | 1 | Claims the shared pins from the normal port logic |
| ad_out | output | 8 | Shared port output: low address, then write data |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input for read data |
| ah_out | output | 8 | High address byte |
| ale | output | 1 | Address latch enable, active high |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |

## Verification
The assertions assume that `req_valid` is seen while the controller is idle only when a new access is meant. They also assume that the control register is not rewritten in the middle of an access. The bench raises each request at a falling edge, holds it for one rising edge, and drops it before the cycle ends. The only exception is the deliberate overlap test for R11, which drops its request while `req_busy` is still high. All register writes happen while the controller is idle, and `ad_in` is held steady at the expected read value for the whole access.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int CFG_W   = 8;
    localparam int SPLIT_W = 3;
    localparam int WS_W    = 2;

    typedef struct packed {
        logic               en;
        logic [SPLIT_W-1:0] split;
        logic [WS_W-1:0]    ws_hi;
        logic [WS_W-1:0]    ws_lo;
    } xcfg_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_STRB,
        PH_HOLD
    } phase_t;

    // Extra strobe cycles beyond the first, per wait setting
    function automatic logic [1:0] strobe_extra(input logic [WS_W-1:0] ws);
        case (ws)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic needs_hold(input logic [WS_W-1:0] ws);
        return ws == 2'b11;
    endfunction

endpackage

// File: rtl/xbus_cfg_reg.sv
module xbus_cfg_reg
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output xcfg_t            cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= xcfg_t'(wdata);
        end
    end

endmodule

// File: rtl/xbus_sector_dec.sv
module xbus_sector_dec
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SPLIT_W-1:0] split,
    input  logic [WS_W-1:0]    ws_lo,
    input  logic [WS_W-1:0]    ws_hi,
    output logic [WS_W-1:0]    ws
);

    localparam int LOW_BITS = ADDR_W - SPLIT_W;

    logic [ADDR_W-1:0] boundary;
    logic              in_lower;

    always_comb begin
        boundary = {split, {LOW_BITS{1'b0}}};
        in_lower = (split != '0) && (addr < boundary);
        ws       = in_lower ? ws_lo : ws_hi;
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [WS_W-1:0]      ws,
    input  logic [DATA_W-1:0]    ad_in,
    output logic                 busy,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    ad_out,
    output logic                 ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic                 ale,
    output logic                 wr_n,
    output logic                 rd_n
);

    phase_t            phase;
    logic [1:0]        cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic              hold_q;
    logic              accept;

    assign accept = req_valid && enable && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            hold_q   <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase   <= PH_ADDR;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        write_q <= req_write;
                        cnt     <= strobe_extra(ws);
                        hold_q  <= needs_hold(ws);
                    end
                end
                PH_ADDR: phase <= PH_STRB;
                PH_STRB: begin
                    if (cnt == 2'd0) begin
                        phase <= hold_q ? PH_HOLD : PH_IDLE;
                        if (!write_q) begin
                            rd_data  <= ad_in;
                            rd_valid <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 2'd1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy   = (phase != PH_IDLE);
        ale    = (phase == PH_ADDR);
        rd_n   = !((phase == PH_STRB) && !write_q);
        wr_n   = !((phase == PH_STRB) && write_q);
        ad_oe  = (phase == PH_ADDR) || ((phase == PH_STRB) && write_q);
        ad_out = (phase == PH_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;
        ah_out = addr_q[ADDR_W-1:DATA_W];
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [CFG_W-1:0]         cfg_wdata,
    output logic [CFG_W-1:0]         cfg_rdata,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_busy,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic                     pin_override,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic                     ale,
    output logic                     wr_n,
    output logic                     rd_n
);

    xcfg_t           cfg;
    logic [WS_W-1:0] ws_sel;

    xbus_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    xbus_sector_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (req_addr),
        .split (cfg.split),
        .ws_lo (cfg.ws_lo),
        .ws_hi (cfg.ws_hi),
        .ws    (ws_sel)
    );

    xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (cfg.en),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ws        (ws_sel),
        .ad_in     (ad_in),
        .busy      (req_busy),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ah_out    (ah_out),
        .ale       (ale),
        .wr_n      (wr_n),
        .rd_n      (rd_n)
    );

    assign cfg_rdata    = cfg;
    assign pin_override = cfg.en;

endmodule

// File: rtl/xbus_chk.sv
module xbus_chk #(
    parameter int AH_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_we,
    input logic            en_wr,
    input logic            req_valid,
    input logic            req_busy,
    input logic            pin_override,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            ad_oe,
    input logic [AH_W-1:0] ah_out,
    input logic            rd_valid
);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    p_ale_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n));

    p_override_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (pin_override == $past(en_wr)));

    p_disabled_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!pin_override && !req_busy) |=> !req_busy);

    p_ale_single_r7: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    p_ah_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (req_busy && !ale) |-> $stable(ah_out));

    p_write_drive_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    p_read_float_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    p_rdvalid_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(!rd_n) && rd_n));

    p_accept_idle_r11: assert property (@(posedge clk) disable iff (rst)
        ale |-> $past(req_valid && !req_busy && pin_override));

endmodule

bind xbus_ctrl xbus_chk #(.AH_W(ADDR_W - DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .en_wr        (cfg_wdata[7]),
    .req_valid    (req_valid),
    .req_busy     (req_busy),
    .pin_override (pin_override),
    .ale          (ale),
    .rd_n         (rd_n),
    .wr_n         (wr_n),
    .ad_oe        (ad_oe),
    .ah_out       (ah_out),
    .rd_valid     (rd_valid)
);

// File: tb/tb_xbus_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [7:0]  cfg_wdata;
    logic [7:0]  cfg_rdata;
    logic        req_valid;
    logic        req_write;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_busy;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        pin_override;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in;
    logic [7:0]  ah_out;
    logic        ale;
    logic        wr_n;
    logic        rd_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    xbus_ctrl dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Runs one access and checks bus behaviour against the requirements
    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                          input int exp_strb, input int exp_busy, input bit poke,
                          input string tag);
        int busy_n = 0, strb_n = 0, ale_n = 0;
        bit ah_bad = 0, adr_bad = 0, oe_bad = 0, wd_bad = 0, both_bad = 0, got_rd = 0;
        logic [7:0] rdv = '0;
        @(negedge clk);
        ad_in     = d;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 30 && req_busy; cyc++) begin
            busy_n++;
            if (ale) begin
                ale_n++;
                if (!(ad_oe && ad_out == a[7:0])) adr_bad = 1;
            end
            if (ah_out != a[15:8]) ah_bad = 1;
            if (!rd_n && !wr_n) both_bad = 1;
            if (!rd_n || !wr_n) strb_n++;
            if (!rd_n && ad_oe) oe_bad = 1;
            if (!wr_n && !(ad_oe && ad_out == d)) wd_bad = 1;
            if (rd_valid) begin got_rd = 1; rdv = rd_data; end
            if (poke && cyc == 1) begin
                req_valid = 1'b1;
                req_addr  = ~a;
            end
            if (poke && cyc == 2) req_valid = 1'b0;
            @(negedge clk);
        end
        if (rd_valid) begin got_rd = 1; rdv = rd_data; end
        chk(busy_n == exp_busy, {tag, " R6 busy cycles"}, busy_n, exp_busy);
        chk(strb_n == exp_strb, {tag, " R6 strobe cycles"}, strb_n, exp_strb);
        chk(ale_n == 1 && !adr_bad, {tag, " R7 ALE phase"}, ale_n, 1);
        chk(!ah_bad, {tag, " R7 high address"}, ah_bad, 0);
        chk(!both_bad, {tag, " R10 strobe overlap"}, both_bad, 0);
        if (wr) begin
            chk(!wd_bad, {tag, " R8 write data"}, wd_bad, 0);
        end else begin
            chk(!oe_bad, {tag, " R9 port released"}, oe_bad, 0);
            chk(got_rd && rdv == d, {tag, " R9 read data"}, rdv, d);
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(!req_busy && ale == 0, {tag, " R11 request while busy ignored"}, req_busy, 0);
        end
    endtask

    task automatic t_reset();
        chk(cfg_rdata == 8'h00, "R1 cfg reset", cfg_rdata, 0);
        chk(!pin_override, "R1 override reset", pin_override, 0);
        chk(!req_busy, "R1 busy reset", req_busy, 0);
        chk(!ale && rd_n && wr_n, "R1 strobes idle", {ale, rd_n, wr_n}, 3);
    endtask

    task automatic t_cfg();
        write_cfg(8'hA5);
        chk(cfg_rdata == 8'hA5, "R2 readback", cfg_rdata, 8'hA5);
        chk(pin_override, "R3 override on", pin_override, 1);
        write_cfg(8'h25);
        chk(cfg_rdata == 8'h25, "R2 readback", cfg_rdata, 8'h25);
        chk(!pin_override, "R3 override off", pin_override, 0);
    endtask

    task automatic t_disabled();
        bit seen = 0;
        write_cfg(8'h0C);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0010; req_wdata = 8'h5A;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (req_busy || ale || !rd_n || !wr_n) seen = 1;
        end
        req_valid = 1'b0;
        chk(!seen, "R3 disabled request ignored", seen, 0);
    endtask

    task automatic t_single();
        // split 0, upper 11, lower 00: all addresses take the upper setting
        write_cfg(8'h8C);
        access(1'b1, 16'h1234, 8'hC3, 3, 5, 1'b0, "R4 single-sector low addr");
        access(1'b0, 16'hF0F0, 8'h69, 3, 5, 1'b0, "R4 single-sector high addr");
    endtask

    task automatic t_split();
        // split 2 (boundary 0x4000), upper 01, lower 10
        write_cfg(8'hA6);
        access(1'b0, 16'h3FFF, 8'h81, 3, 4, 1'b0, "R5 below boundary");
        access(1'b0, 16'h4000, 8'h7E, 2, 3, 1'b0, "R5 at boundary");
        // split 7 (boundary 0xE000), upper 00, lower 11
        write_cfg(8'hF3);
        access(1'b1, 16'hF000, 8'h11, 1, 2, 1'b0, "R5 R6 upper no wait");
        access(1'b0, 16'hDFFF, 8'hEE, 3, 5, 1'b0, "R5 R6 lower with hold");
    endtask

    task automatic t_overlap();
        write_cfg(8'h8C);
        access(1'b1, 16'h0A55, 8'h3C, 3, 5, 1'b1, "R11 overlap");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; ad_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_disabled();
        t_single();
        t_split();
        t_overlap();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule